// File: doc/BRIEF.md
# Flash command decoder and mode tracker

This block sits behind the command port of a flash-style memory. Each bus write carries a command byte on the low eight data lines. The block turns these bytes into a device mode. The modes are: idle read, program setup, program running, program suspended, erase setup, erase running and erase suspended. When a command is accepted, the block raises a one-cycle start, suspend or resume strobe toward the internal write engine. The engine answers with a done pulse when the operation has finished.

Each mode has its own list of accepted commands. A byte that is not on the list for the current mode leaves the mode unchanged and sets a sticky sequence-error flag. The block can start a program while an erase is suspended. That program runs as a nested operation, and when it completes the block goes back to erase-suspended. Four read commands choose what the bus would return: array, status, query or protection data. Pulling the asynchronous active-low reset low aborts any operation in progress.

Top module: `flash_cmd_fsm`

## Requirements
- R1: While rst_ni is low, the block is forced at once to mode 0 (idle), with all strobes low, busy_o, susp_o and seq_err_o low, and rd_sel_o at 0. This holds even in the middle of a running program.
- R2: Four commands select the read source on rd_sel_o: FFh gives 0 (array), 70h gives 1 (status), 98h gives 2 (query) and 90h gives 3 (protection). They are accepted in idle, program-suspended and erase-suspended modes.
- R3: In idle, 40h enters program setup (mode 1). The next write, whatever its value, moves the block to program running (mode 2) and pulses start_prog_o for one cycle after that write.
- R4: In idle, 20h enters erase setup (mode 4). If the next write is D0h, the block moves to erase running (mode 5) and pulses start_erase_o. Any other byte returns the block to idle, raises no strobe and sets seq_err_o.
- R5: In program running (mode 2) or erase running (mode 5), only B0h is accepted. It moves the block to the matching suspended mode (3 or 6) and pulses suspend_o. Every other byte leaves the mode unchanged.
- R6: In program-suspended mode, the block accepts the read commands, 40h (accepted with no effect) and D0h. D0h pulses resume_o and returns the block to mode 2. Everything else is rejected.
- R7: In erase-suspended mode, the block accepts the read commands, 60h (lock setup, accepted with no effect), 40h (enters a nested program setup) and D0h. D0h pulses resume_o and returns the block to mode 5. Everything else is rejected.
- R8: A rejected command sets seq_err_o, and it stays set until 50h is written in idle, which clears it. In idle, the accepted bytes are FFh, 70h, 98h, 90h, 50h, 40h, 20h and 60h.
- R9: A done_i pulse in a running mode returns the block to idle with rd_sel_o at 0. If the program was nested under a suspended erase, the block returns instead to mode 6.
- R10: done_i in a running mode takes priority over a write in the same cycle, and that write is dropped without setting an error. done_i in any other mode has no effect.
- R11: busy_o is high exactly in modes 2 and 5, and susp_o exactly in modes 3 and 6. At most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; aborts any operation |
| wr_en_i | input | 1 | Bus write strobe, one cycle per write |
| wr_data_i | input | DATA_W | Bus write data; command byte on bits 7:0 |
| done_i | input | 1 | Operation complete pulse from the write engine |
| start_prog_o | output | 1 | Program start strobe |
| start_erase_o | output | 1 | Erase start strobe |
| suspend_o | output | 1 | Suspend strobe |
| resume_o | output | 1 | Resume strobe |
| mode_o | output | 3 | Current mode code |
| busy_o | output | 1 | Write engine operation running |
| susp_o | output | 1 | Operation suspended |
| seq_err_o | output | 1 | Sticky sequence-error flag |
| rd_sel_o | output | 2 | Selected read source |

## Verification
The bench targets these corner cases:
- **Second erase byte other than D0h.** A design that only looked for D0h somewhere later would leave erase setup pending or start an erase by mistake.
- **Read or erase bytes during a running or suspended program.** A design that shared one allow-list across modes would change the read source, or launch an erase, in the middle of an operation.
- **Nested program under a suspended erase.** A design that forgot the nesting would drop to idle on completion and lose the suspended erase.
- **done_i and B0h in the same cycle.** The bench checks that the pair produces no suspend strobe.
- **Reset mid-program.** The bench checks that reset clears the busy and strobe state at once.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    M_IDLE   = 3'd0,
    M_PSETUP = 3'd1,
    M_PRUN   = 3'd2,
    M_PSUSP  = 3'd3,
    M_ESETUP = 3'd4,
    M_ERUN   = 3'd5,
    M_ESUSP  = 3'd6
  } mode_e;

  typedef enum logic [3:0] {
    C_RD_ARRAY, C_RD_STAT, C_RD_QUERY, C_RD_PROT,
    C_CLR_ERR, C_PROG, C_ERASE, C_CONFIRM,
    C_SUSPEND, C_LOCK, C_OTHER
  } cmd_e;

  localparam logic [7:0] OP_RD_ARRAY = 8'hFF;
  localparam logic [7:0] OP_RD_STAT  = 8'h70;
  localparam logic [7:0] OP_RD_QUERY = 8'h98;
  localparam logic [7:0] OP_RD_PROT  = 8'h90;
  localparam logic [7:0] OP_CLR_ERR  = 8'h50;
  localparam logic [7:0] OP_PROG     = 8'h40;
  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
  localparam logic [7:0] OP_SUSPEND  = 8'hB0;
  localparam logic [7:0] OP_LOCK     = 8'h60;

  localparam logic [1:0] RS_ARRAY = 2'd0;
  localparam logic [1:0] RS_STAT  = 2'd1;
  localparam logic [1:0] RS_QUERY = 2'd2;
  localparam logic [1:0] RS_PROT  = 2'd3;

  function automatic logic is_read(cmd_e c);
    return (c == C_RD_ARRAY) || (c == C_RD_STAT) || (c == C_RD_QUERY) || (c == C_RD_PROT);
  endfunction
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CMD_W  = 8
) (
  input  logic [DATA_W-1:0] data_i,
  output cmd_e              cmd_o
);
  localparam int UNUSED_W = DATA_W - CMD_W;

  logic [CMD_W-1:0] op;
  assign op = data_i[CMD_W-1:0];

  // upper lines carry no command information
  generate
    if (UNUSED_W > 0) begin : g_upper
      logic [UNUSED_W-1:0] upper_unused;
      assign upper_unused = data_i[DATA_W-1:CMD_W];
    end
  endgenerate

  always_comb begin
    unique case (op)
      OP_RD_ARRAY: cmd_o = C_RD_ARRAY;
      OP_RD_STAT:  cmd_o = C_RD_STAT;
      OP_RD_QUERY: cmd_o = C_RD_QUERY;
      OP_RD_PROT:  cmd_o = C_RD_PROT;
      OP_CLR_ERR:  cmd_o = C_CLR_ERR;
      OP_PROG:     cmd_o = C_PROG;
      OP_ERASE:    cmd_o = C_ERASE;
      OP_CONFIRM:  cmd_o = C_CONFIRM;
      OP_SUSPEND:  cmd_o = C_SUSPEND;
      OP_LOCK:     cmd_o = C_LOCK;
      default:     cmd_o = C_OTHER;
    endcase
  end
endmodule

// File: rtl/flash_cmd_filter.sv
module flash_cmd_filter
  import flash_cmd_pkg::*;
(
  input  mode_e mode_i,
  input  cmd_e  cmd_i,
  output logic  accept_o
);
  always_comb begin
    accept_o = 1'b0;
    unique case (mode_i)
      M_IDLE:   accept_o = is_read(cmd_i) || (cmd_i == C_CLR_ERR) || (cmd_i == C_PROG) ||
                           (cmd_i == C_ERASE) || (cmd_i == C_LOCK);
      M_PSETUP: accept_o = 1'b1;  // data word, any value
      M_ESETUP: accept_o = (cmd_i == C_CONFIRM);
      M_PRUN,
      M_ERUN:   accept_o = (cmd_i == C_SUSPEND);
      M_PSUSP:  accept_o = is_read(cmd_i) || (cmd_i == C_PROG) || (cmd_i == C_CONFIRM);
      M_ESUSP:  accept_o = is_read(cmd_i) || (cmd_i == C_PROG) || (cmd_i == C_CONFIRM) ||
                           (cmd_i == C_LOCK);
      default:  accept_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl
  import flash_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  cmd_e       cmd_i,
  input  logic       accept_i,
  input  logic       done_i,
  output mode_e      mode_o,
  output logic       start_prog_o,
  output logic       start_erase_o,
  output logic       suspend_o,
  output logic       resume_o,
  output logic       seq_err_o,
  output logic [1:0] rd_sel_o
);
  mode_e      mode_q, mode_d;
  logic       nest_q, nest_d;
  logic       err_q, err_d;
  logic [1:0] rsel_q, rsel_d;
  logic [3:0] strb_d, strb_q;  // {prog, erase, suspend, resume}
  logic       running;

  assign running = (mode_q == M_PRUN) || (mode_q == M_ERUN);

  function automatic logic [1:0] rsel_of(cmd_e c, logic [1:0] cur);
    unique case (c)
      C_RD_ARRAY: return RS_ARRAY;
      C_RD_STAT:  return RS_STAT;
      C_RD_QUERY: return RS_QUERY;
      C_RD_PROT:  return RS_PROT;
      default:    return cur;
    endcase
  endfunction

  always_comb begin
    mode_d = mode_q;
    nest_d = nest_q;
    err_d  = err_q;
    rsel_d = rsel_q;
    strb_d = 4'b0000;
    if (done_i && running) begin
      rsel_d = RS_ARRAY;
      if (mode_q == M_PRUN && nest_q) begin
        mode_d = M_ESUSP;
        nest_d = 1'b0;
      end else begin
        mode_d = M_IDLE;
      end
    end else if (wr_en_i) begin
      if (!accept_i) begin
        err_d = 1'b1;
        if (mode_q == M_ESETUP) mode_d = M_IDLE;
      end else begin
        unique case (mode_q)
          M_IDLE: begin
            rsel_d = rsel_of(cmd_i, rsel_q);
            if (cmd_i == C_CLR_ERR) err_d = 1'b0;
            if (cmd_i == C_PROG) mode_d = M_PSETUP;
            if (cmd_i == C_ERASE) mode_d = M_ESETUP;
          end
          M_PSETUP: begin
            mode_d = M_PRUN;
            strb_d = 4'b1000;
          end
          M_ESETUP: begin
            mode_d = M_ERUN;
            strb_d = 4'b0100;
          end
          M_PRUN: begin
            mode_d = M_PSUSP;
            strb_d = 4'b0010;
          end
          M_ERUN: begin
            mode_d = M_ESUSP;
            strb_d = 4'b0010;
          end
          M_PSUSP: begin
            rsel_d = rsel_of(cmd_i, rsel_q);
            if (cmd_i == C_CONFIRM) begin
              mode_d = M_PRUN;
              strb_d = 4'b0001;
            end
          end
          M_ESUSP: begin
            rsel_d = rsel_of(cmd_i, rsel_q);
            if (cmd_i == C_CONFIRM) begin
              mode_d = M_ERUN;
              strb_d = 4'b0001;
            end else if (cmd_i == C_PROG) begin
              mode_d = M_PSETUP;
              nest_d = 1'b1;
            end
          end
          default: mode_d = M_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_IDLE;
      nest_q <= 1'b0;
      err_q  <= 1'b0;
      rsel_q <= RS_ARRAY;
      strb_q <= 4'b0000;
    end else begin
      mode_q <= mode_d;
      nest_q <= nest_d;
      err_q  <= err_d;
      rsel_q <= rsel_d;
      strb_q <= strb_d;
    end
  end

  assign mode_o        = mode_q;
  assign seq_err_o     = err_q;
  assign rd_sel_o      = rsel_q;
  assign start_prog_o  = strb_q[3];
  assign start_erase_o = strb_q[2];
  assign suspend_o     = strb_q[1];
  assign resume_o      = strb_q[0];
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              done_i,
  output logic              start_prog_o,
  output logic              start_erase_o,
  output logic              suspend_o,
  output logic              resume_o,
  output logic [2:0]        mode_o,
  output logic              busy_o,
  output logic              susp_o,
  output logic              seq_err_o,
  output logic [1:0]        rd_sel_o
);
  localparam int CMD_W = 8;

  cmd_e  cmd;
  logic  accept;
  mode_e mode;

  flash_cmd_decode #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_decode (
    .data_i (wr_data_i),
    .cmd_o  (cmd)
  );

  flash_cmd_filter u_filter (
    .mode_i   (mode),
    .cmd_i    (cmd),
    .accept_o (accept)
  );

  flash_mode_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .cmd_i         (cmd),
    .accept_i      (accept),
    .done_i        (done_i),
    .mode_o        (mode),
    .start_prog_o  (start_prog_o),
    .start_erase_o (start_erase_o),
    .suspend_o     (suspend_o),
    .resume_o      (resume_o),
    .seq_err_o     (seq_err_o),
    .rd_sel_o      (rd_sel_o)
  );

  assign mode_o = mode;
  assign busy_o = (mode == M_PRUN) || (mode == M_ERUN);
  assign susp_o = (mode == M_PSUSP) || (mode == M_ESUSP);
endmodule

// File: rtl/flash_cmd_fsm_chk.sv
module flash_cmd_fsm_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              done_i,
  input logic              start_prog_o,
  input logic              start_erase_o,
  input logic              suspend_o,
  input logic              resume_o,
  input logic [2:0]        mode_o,
  input logic              busy_o,
  input logic              susp_o,
  input logic              seq_err_o,
  input logic [1:0]        rd_sel_o
);
  p_prog_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_prog_o |-> (busy_o && mode_o == 3'd2));

  p_erase_confirm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_erase_o |-> ($past(mode_o) == 3'd4 && $past(wr_en_i) && $past(wr_data_i[7:0]) == 8'hD0));

  p_run_filter_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == 3'd2 || mode_o == 3'd5) && wr_en_i && wr_data_i[7:0] != 8'hB0 && !done_i)
    |=> $stable(mode_o));

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_err_o && !(wr_en_i && wr_data_i[7:0] == 8'h50 && mode_o == 3'd0)) |=> seq_err_o);

  p_done_exit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == 3'd2 || mode_o == 3'd5) && done_i) |=> (!busy_o && rd_sel_o == 2'd0));

  p_strobe_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_prog_o, start_erase_o, suspend_o, resume_o}));

  p_busy_susp_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && susp_o));
endmodule

bind flash_cmd_fsm flash_cmd_fsm_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/flash_cmd_fsm_tb_top.sv
module flash_cmd_fsm_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        done = 1'b0;
  logic        st_prog, st_erase, susp_p, res_p, busy, susp, err;
  logic [2:0]  mode;
  logic [1:0]  rsel;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [10:0] exp_q[$];  // {mode[2:0], strobes[3:0], err, rsel[1:0], pad}
  string       tag_q[$];

  always #2 clk = ~clk;

  flash_cmd_fsm dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .done_i(done),
    .start_prog_o(st_prog), .start_erase_o(st_erase), .suspend_o(susp_p), .resume_o(res_p),
    .mode_o(mode), .busy_o(busy), .susp_o(susp), .seq_err_o(err), .rd_sel_o(rsel)
  );

  // monitor: pops one expected item per cycle
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [10:0] e;
        logic [10:0] a;
        string t;
        logic eb, es;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        eb = (e[10:8] == 3'd2) || (e[10:8] == 3'd5);
        es = (e[10:8] == 3'd3) || (e[10:8] == 3'd6);
        a = {mode, st_prog, st_erase, susp_p, res_p, err, rsel, 1'b0};
        checks++;
        if (a !== e || busy !== eb || susp !== es) begin
          errors++;
          $display("FAIL %s: mode/strb/err/rsel=%h busy=%b susp=%b expected %h busy=%b susp=%b",
                   t, a, busy, susp, e, eb, es);
        end
      end
    end
  end

  task automatic step(input logic w, input logic [15:0] d, input logic dn,
                      input logic [2:0] em, input logic [3:0] es, input logic ee,
                      input logic [1:0] er, input string t);
    @(negedge clk);
    wr_en = w; wr_data = d; done = dn;
    @(posedge clk);
    #1;
    wr_en = 1'b0; done = 1'b0;
    exp_q.push_back({em, es, ee, er, 1'b0});
    tag_q.push_back(t);
  endtask

  task automatic direct(input logic cond, input string t);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: mode=%0d busy=%b strobes=%b err=%b rsel=%0d expected idle/all zero",
               t, mode, busy, {st_prog, st_erase, susp_p, res_p}, err, rsel);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    direct(mode == 0 && !busy && !susp && !err && rsel == 0 &&
           {st_prog, st_erase, susp_p, res_p} == 4'b0, "R1 reset");
    rst_n = 1'b1;
    // R2 read selection in idle
    step(1, 16'h0070, 0, 3'd0, 4'b0000, 0, 2'd1, "R2 status");
    step(1, 16'h0098, 0, 3'd0, 4'b0000, 0, 2'd2, "R2 query");
    step(1, 16'h0090, 0, 3'd0, 4'b0000, 0, 2'd3, "R2 prot");
    step(1, 16'h00FF, 0, 3'd0, 4'b0000, 0, 2'd0, "R2 array");
    // R3 program
    step(1, 16'h0040, 0, 3'd1, 4'b0000, 0, 2'd0, "R3 setup");
    step(1, 16'h1270, 0, 3'd2, 4'b1000, 0, 2'd0, "R3 data start");
    step(1, 16'h0070, 0, 3'd2, 4'b0000, 1, 2'd0, "R5 read rejected in run");
    step(0, 16'h0000, 0, 3'd2, 4'b0000, 1, 2'd0, "R3 strobe single");
    step(1, 16'h00B0, 0, 3'd3, 4'b0010, 1, 2'd0, "R5 program suspend");
    step(1, 16'h0070, 0, 3'd3, 4'b0000, 1, 2'd1, "R6 read in psusp");
    step(1, 16'h0040, 0, 3'd3, 4'b0000, 1, 2'd1, "R6 setup no effect");
    step(1, 16'h0020, 0, 3'd3, 4'b0000, 1, 2'd1, "R6 erase rejected");
    step(1, 16'h00D0, 0, 3'd2, 4'b0001, 1, 2'd1, "R6 resume");
    step(1, 16'h0070, 1, 3'd0, 4'b0000, 1, 2'd0, "R9 R10 done wins");
    step(1, 16'h0050, 0, 3'd0, 4'b0000, 0, 2'd0, "R8 clear");
    // R4 erase
    step(1, 16'h0020, 0, 3'd4, 4'b0000, 0, 2'd0, "R4 setup");
    step(1, 16'h0040, 0, 3'd0, 4'b0000, 1, 2'd0, "R4 bad confirm");
    step(1, 16'h0050, 0, 3'd0, 4'b0000, 0, 2'd0, "R8 clear again");
    step(1, 16'h0020, 0, 3'd4, 4'b0000, 0, 2'd0, "R4 setup 2");
    step(1, 16'h00D0, 0, 3'd5, 4'b0100, 0, 2'd0, "R4 confirm");
    step(1, 16'h00FF, 0, 3'd5, 4'b0000, 1, 2'd0, "R5 erase run filter");
    step(1, 16'h00B0, 0, 3'd6, 4'b0010, 1, 2'd0, "R5 erase suspend");
    step(1, 16'h0060, 0, 3'd6, 4'b0000, 1, 2'd0, "R7 lock no effect");
    step(1, 16'h0050, 0, 3'd6, 4'b0000, 1, 2'd0, "R7 R8 clear rejected");
    step(1, 16'h0098, 0, 3'd6, 4'b0000, 1, 2'd2, "R7 query");
    step(0, 16'h0000, 1, 3'd6, 4'b0000, 1, 2'd2, "R10 done ignored in esusp");
    step(1, 16'h0040, 0, 3'd1, 4'b0000, 1, 2'd2, "R7 nested setup");
    step(1, 16'h00D0, 0, 3'd2, 4'b1000, 1, 2'd2, "R7 nested start");
    step(0, 16'h0000, 1, 3'd6, 4'b0000, 1, 2'd0, "R9 nested return");
    step(1, 16'h00D0, 0, 3'd5, 4'b0001, 1, 2'd0, "R7 erase resume");
    step(1, 16'h00B0, 1, 3'd0, 4'b0000, 1, 2'd0, "R10 done beats suspend");
    step(1, 16'h0050, 0, 3'd0, 4'b0000, 0, 2'd0, "R8 clear 3");
    step(1, 16'h00AB, 0, 3'd0, 4'b0000, 1, 2'd0, "R8 unknown idle");
    step(1, 16'h0050, 0, 3'd0, 4'b0000, 0, 2'd0, "R8 clear 4");
    step(1, 16'h0060, 0, 3'd0, 4'b0000, 0, 2'd0, "R8 lock accepted idle");
    step(1, 16'h0040, 0, 3'd1, 4'b0000, 0, 2'd0, "R3 setup 2");
    step(1, 16'h0000, 0, 3'd2, 4'b1000, 0, 2'd0, "R3 start 2");
    // R1 abort mid-program
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    direct(mode == 0 && !busy && !susp && !err && rsel == 0 &&
           {st_prog, st_erase, susp_p, res_p} == 4'b0, "R1 abort");
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 16'h0070, 0, 3'd0, 4'b0000, 0, 2'd1, "R1 R2 after abort");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule